// File: doc/BRIEF.md
# Serial Controller Indirect Register Window

This block sits between a host register port and the byte-wide internal registers of a two-wire serial controller. The host writes one 64-bit command word. The word carries a busy flag, an operation code, a direction flag, a 3-bit internal address and a data byte. For as long as the busy flag is set, the block carries out the internal access. At the end it places the result byte in the data field and clears the busy flag. Software polls the flag to learn that the access is over.

Four internal targets are reachable through the window:
- A control byte, which can be written and read.
- A transmit/receive data register. A write loads the transmit byte and a read fetches the receive byte, each with a strobe.
- A clock divider, which can only be written.
- A status byte, which can only be read.

The clock divider and the status byte share one address, and the direction flag picks between them. The serial engine behind the window supplies the status and receive bytes. It consumes the control byte, the transmit byte, the divider fields and the strobes.

Command word layout:

| Bits | Field |
|---|---|
| 63 | busy flag |
| 62:15 | held as written, no meaning |
| 14:12 | operation code |
| 11 | direction (1 = read) |
| 10:8 | internal address |
| 7:0 | data byte |

Top module: `twi_cmd_window`

## Requirements
- R1: When a command finishes, bit 63 of `host_rd_data` reads 0 from the next cycle on. The word keeps every other field except the data byte.
- R2: A command with operation code 6, written while idle with bit 63 set, keeps bit 63 at 1 for exactly LATENCY cycles (default 2) after the write edge.
- R3: At most one internal strobe is active in any cycle, and only in the final cycle of a command. Operation code 6 decodes internal address 0 as data, 2 as control and 3 as the shared divider/status address.
- R4: Address 3 with direction 0 loads the divider: `div_m` takes data bits 6:3 and `div_n` takes data bits 2:0. Bit 7 is dropped, and `div_wr` pulses once.
- R5: Address 3 with direction 1 returns `status_byte` in bits 7:0 of the word and leaves the divider unchanged.
- R6: Address 2 with direction 0 loads `ctrl_byte` and pulses `ctrl_wr`. With direction 1 it returns the current `ctrl_byte` in bits 7:0.
- R7: Address 0 with direction 0 loads `tx_byte` and pulses `tx_wr`. With direction 1 it returns `rx_byte` in bits 7:0 and pulses `rx_rd`.
- R8: A host write that arrives while bit 63 reads 1 has no effect: the word, the strobes and the registers stay as the running command leaves them.
- R9: An operation code other than 6 keeps bit 63 high for one cycle, clears the data byte to 0, fires no strobe and changes no register.
- R10: Operation code 6 with address 1, 4, 5, 6 or 7 takes LATENCY cycles and fires no strobe. A read returns 0 in the data byte; a write leaves the data byte as written.
- R11: After reset the word, `ctrl_byte`, `tx_byte`, `div_m` and `div_n` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr_en | input | 1 | Host writes the command word this cycle |
| host_wr_data | input | 64 | Command word written by the host |
| host_rd_data | output | 64 | Current command word, including busy flag and result |
| ctrl_byte | output | 8 | Control register toward the serial engine |
| ctrl_wr | output | 1 | Control register write strobe |
| tx_byte | output | 8 | Transmit data byte toward the serial engine |
| tx_wr | output | 1 | Transmit byte load strobe |
| rx_byte | input | 8 | Receive data byte from the serial engine |
| rx_rd | output | 1 | Receive byte fetch strobe |
| status_byte | input | 8 | Status byte from the serial engine |
| div_m | output | 4 | Clock divider M field |
| div_n | output | 3 | Clock divider N exponent |
| div_wr | output | 1 | Clock divider write strobe |

## Verification
A host write is taken at a clock edge. For a valid operation code the busy flag then stays high for LATENCY cycles, and for an unknown code it stays high for one cycle. The result byte, the register outputs and the busy flag all change together at the edge where the flag falls. The one-cycle strobe sits in the cycle just before that edge. The bench applies every write at a falling edge and counts the falling edges at which the flag still reads high, then compares that count with the expected duration. Strobes are counted at rising edges, and data and register values are read only after the flag has fallen.

// File: rtl/twi_win_pkg.sv
package twi_win_pkg;

  localparam int WORD_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int OP_W     = 3;
  localparam int ADDR_W   = 3;
  localparam int M_W      = 4;
  localparam int N_W      = 3;

  localparam int BIT_BUSY = 63;
  localparam int OP_LSB   = 12;
  localparam int BIT_DIR  = 11;
  localparam int ADDR_LSB = 8;
  localparam int DECODE_W = OP_LSB + OP_W;

  localparam logic [OP_W-1:0]   OP_REGACC   = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SHARED = 3'd3;

  typedef enum logic [2:0] {
    TGT_BADOP  = 3'd0,
    TGT_DATA   = 3'd1,
    TGT_CTRL   = 3'd2,
    TGT_CLKDIV = 3'd3,
    TGT_STATUS = 3'd4,
    TGT_NONE   = 3'd5
  } tgt_e;

  function automatic tgt_e decode_target(input logic [OP_W-1:0] op,
                                         input logic dir_rd,
                                         input logic [ADDR_W-1:0] addr);
    tgt_e t;
    if (op != OP_REGACC) begin
      t = TGT_BADOP;
    end else begin
      case (addr)
        ADDR_DATA:   t = TGT_DATA;
        ADDR_CTRL:   t = TGT_CTRL;
        ADDR_SHARED: t = dir_rd ? TGT_STATUS : TGT_CLKDIV;
        default:     t = TGT_NONE;
      endcase
    end
    return t;
  endfunction

  function automatic logic [M_W-1:0] div_m_of(input logic [BYTE_W-1:0] b);
    return b[N_W +: M_W];
  endfunction

  function automatic logic [N_W-1:0] div_n_of(input logic [BYTE_W-1:0] b);
    return b[N_W-1:0];
  endfunction

endpackage

// File: rtl/twi_cmd_decode.sv
module twi_cmd_decode
  import twi_win_pkg::*;
(
  input  logic [DECODE_W-ADDR_LSB-1:0] fields,
  output tgt_e                         tgt
);
  localparam int OFS_OP  = OP_LSB - ADDR_LSB;
  localparam int OFS_DIR = BIT_DIR - ADDR_LSB;

  always_comb begin
    tgt = decode_target(fields[OFS_OP +: OP_W], fields[OFS_DIR],
                        fields[ADDR_W-1:0]);
  end
endmodule

// File: rtl/twi_cmd_seq.sv
module twi_cmd_seq
  import twi_win_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wr_data,
  input  logic              in_known,
  input  logic [BYTE_W-1:0] result_byte,
  output logic [WORD_W-1:0] word_q,
  output logic              busy,
  output logic              finishing
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] LOAD_KNOWN = CW'(LATENCY - 1);

  logic [CW-1:0] cnt_q;
  logic          accept;

  assign busy      = word_q[BIT_BUSY];
  assign finishing = busy && (cnt_q == '0);
  assign accept    = !busy && host_wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (finishing) begin
      word_q[BIT_BUSY]     <= 1'b0;
      word_q[BYTE_W-1:0]   <= result_byte;
    end else if (accept) begin
      word_q <= host_wr_data;
      cnt_q  <= in_known ? LOAD_KNOWN : '0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  initial begin
    if (LATENCY < 1) $error("LATENCY must be at least 1");
  end
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finishing,
  input  tgt_e              tgt,
  input  logic              dir_rd,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] status_byte,
  output logic [BYTE_W-1:0] result_byte,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic              ctrl_wr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_wr,
  output logic              rx_rd,
  output logic [M_W-1:0]    div_m,
  output logic [N_W-1:0]    div_n,
  output logic              div_wr
);
  logic [BYTE_W-1:0] ctrl_q, tx_q;
  logic [M_W-1:0]    m_q;
  logic [N_W-1:0]    n_q;

  assign ctrl_wr = finishing && (tgt == TGT_CTRL) && !dir_rd;
  assign tx_wr   = finishing && (tgt == TGT_DATA) && !dir_rd;
  assign rx_rd   = finishing && (tgt == TGT_DATA) && dir_rd;
  assign div_wr  = finishing && (tgt == TGT_CLKDIV);

  always_comb begin
    case (tgt)
      TGT_DATA:   result_byte = dir_rd ? rx_byte : cmd_byte;
      TGT_CTRL:   result_byte = dir_rd ? ctrl_q : cmd_byte;
      TGT_STATUS: result_byte = status_byte;
      TGT_CLKDIV: result_byte = cmd_byte;
      TGT_NONE:   result_byte = dir_rd ? '0 : cmd_byte;
      default:    result_byte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_q   <= '0;
      m_q    <= '0;
      n_q    <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= cmd_byte;
      if (tx_wr)   tx_q   <= cmd_byte;
      if (div_wr) begin
        m_q <= div_m_of(cmd_byte);
        n_q <= div_n_of(cmd_byte);
      end
    end
  end

  assign ctrl_byte = ctrl_q;
  assign tx_byte   = tx_q;
  assign div_m     = m_q;
  assign div_n     = n_q;
endmodule

// File: rtl/twi_cmd_window.sv
module twi_cmd_window
  import twi_win_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [63:0] host_wr_data,
  output logic [63:0] host_rd_data,
  output logic [7:0]  ctrl_byte,
  output logic        ctrl_wr,
  output logic [7:0]  tx_byte,
  output logic        tx_wr,
  input  logic [7:0]  rx_byte,
  output logic        rx_rd,
  input  logic [7:0]  status_byte,
  output logic [3:0]  div_m,
  output logic [2:0]  div_n,
  output logic        div_wr
);
  tgt_e              in_tgt, hold_tgt;
  logic              in_known;
  logic              busy, finishing, hold_bad;
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] result_byte;

  twi_cmd_decode u_dec_in (
    .fields (host_wr_data[DECODE_W-1:ADDR_LSB]),
    .tgt    (in_tgt)
  );

  twi_cmd_decode u_dec_hold (
    .fields (word_q[DECODE_W-1:ADDR_LSB]),
    .tgt    (hold_tgt)
  );

  assign in_known = (in_tgt != TGT_BADOP);
  assign hold_bad = (hold_tgt == TGT_BADOP);

  twi_cmd_seq #(.LATENCY(LATENCY)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .in_known     (in_known),
    .result_byte  (result_byte),
    .word_q       (word_q),
    .busy         (busy),
    .finishing    (finishing)
  );

  twi_reg_bank u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .finishing   (finishing),
    .tgt         (hold_tgt),
    .dir_rd      (word_q[BIT_DIR]),
    .cmd_byte    (word_q[BYTE_W-1:0]),
    .rx_byte     (rx_byte),
    .status_byte (status_byte),
    .result_byte (result_byte),
    .ctrl_byte   (ctrl_byte),
    .ctrl_wr     (ctrl_wr),
    .tx_byte     (tx_byte),
    .tx_wr       (tx_wr),
    .rx_rd       (rx_rd),
    .div_m       (div_m),
    .div_n       (div_n),
    .div_wr      (div_wr)
  );

  assign host_rd_data = word_q;
endmodule

// File: rtl/twi_cmd_window_chk.sv
module twi_cmd_window_chk #(
  parameter int LATENCY = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] host_rd_data,
  input logic        finishing,
  input logic        hold_bad,
  input logic [7:0]  ctrl_byte,
  input logic        ctrl_wr,
  input logic        tx_wr,
  input logic        rx_rd,
  input logic [3:0]  div_m,
  input logic [2:0]  div_n,
  input logic        div_wr
);
  int unsigned busy_cyc;
  logic        any_strobe;

  assign any_strobe = ctrl_wr | tx_wr | rx_rd | div_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy_cyc <= 0;
    else if (host_rd_data[63]) busy_cyc <= busy_cyc + 1;
    else                       busy_cyc <= 0;
  end

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    finishing |=> !host_rd_data[63]); // R1
  AST_BOUNDED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_data[63] |-> busy_cyc < LATENCY); // R2
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, tx_wr, rx_rd, div_wr})); // R3
  AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> finishing); // R3
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wr |=> $stable({div_m, div_n})); // R4
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_byte)); // R6
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data[63] && !finishing) |=> $stable(host_rd_data)); // R8
  AST_BADOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_bad && host_rd_data[63]) |-> (finishing && !any_strobe)); // R9
endmodule

bind twi_cmd_window twi_cmd_window_chk #(.LATENCY(LATENCY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_rd_data (host_rd_data),
  .finishing    (finishing),
  .hold_bad     (hold_bad),
  .ctrl_byte    (ctrl_byte),
  .ctrl_wr      (ctrl_wr),
  .tx_wr        (tx_wr),
  .rx_rd        (rx_rd),
  .div_m        (div_m),
  .div_n        (div_n),
  .div_wr       (div_wr)
);

// File: tb/twi_cmd_window_bench.sv
`timescale 1ns/1ps
module twi_cmd_window_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [63:0] host_wr_data = '0;
  logic [63:0] host_rd_data;
  logic [7:0]  ctrl_byte, tx_byte;
  logic        ctrl_wr, tx_wr, rx_rd, div_wr;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  status_byte = '0;
  logic [3:0]  div_m;
  logic [2:0]  div_n;

  int checks = 0;
  int errors = 0;
  int n_ctrl = 0, n_tx = 0, n_rx = 0, n_div = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  twi_cmd_window #(.LATENCY(LAT)) u_twi_cmd_window (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .ctrl_byte(ctrl_byte), .ctrl_wr(ctrl_wr), .tx_byte(tx_byte),
    .tx_wr(tx_wr), .rx_byte(rx_byte), .rx_rd(rx_rd),
    .status_byte(status_byte), .div_m(div_m), .div_n(div_n),
    .div_wr(div_wr)
  );

  always @(posedge clk) begin
    if (ctrl_wr) n_ctrl++;
    if (tx_wr)   n_tx++;
    if (rx_rd)   n_rx++;
    if (div_wr)  n_div++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run exceeded its cycle budget (actual %0d expected <= 100000)", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] mk(input logic v, input logic [2:0] op,
                                      input logic rd, input logic [2:0] a,
                                      input logic [7:0] d);
    return {v, 48'h0, op, rd, a, d};
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] w);
    host_wr_data = w;
    host_wr_en   = 1'b1;
    @(negedge clk);
    host_wr_en   = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int exp_hi);
    int hi = 0;
    while (host_rd_data[63] && hi < 50) begin
      hi++;
      @(negedge clk);
    end
    check(tag, hi, exp_hi);
  endtask

  task automatic t_reset();
    check("R11 word after reset", host_rd_data, 64'h0);
    check("R11 control after reset", ctrl_byte, 8'h0);
    check("R11 tx after reset", tx_byte, 8'h0);
    check("R11 divider after reset", {div_m, div_n}, 7'h0);
  endtask

  task automatic t_ctrl();
    logic [63:0] w = mk(1'b1, 3'd6, 1'b0, 3'd2, 8'h4C);
    int c0 = n_ctrl;
    issue(w);
    wait_done("R2 control write duration", LAT);
    check("R1 busy flag clear, fields kept", host_rd_data, {1'b0, w[62:0]});
    check("R6 control byte loaded", ctrl_byte, 8'h4C);
    check("R6 one control strobe", n_ctrl - c0, 1);
    issue(mk(1'b1, 3'd6, 1'b1, 3'd2, 8'h00));
    wait_done("R2 control read duration", LAT);
    check("R6 control read back", host_rd_data[7:0], 8'h4C);
    check("R6 control read has no strobe", n_ctrl - c0, 1);
  endtask

  task automatic t_div();
    int d0 = n_div;
    issue(mk(1'b1, 3'd6, 1'b0, 3'd3, 8'h5D));
    wait_done("R4 divider write duration", LAT);
    check("R4 div_m from bits 6:3", div_m, 4'hB);
    check("R4 div_n from bits 2:0", div_n, 3'd5);
    issue(mk(1'b1, 3'd6, 1'b0, 3'd3, 8'hA2));
    wait_done("R4 divider write duration", LAT);
    check("R4 bit 7 dropped, M", div_m, 4'h4);
    check("R4 bit 7 dropped, N", div_n, 3'd2);
    check("R4 divider strobes", n_div - d0, 2);
  endtask

  task automatic t_status();
    int d0 = n_div;
    status_byte = 8'hF8;
    issue(mk(1'b1, 3'd6, 1'b1, 3'd3, 8'h00));
    wait_done("R5 status read duration", LAT);
    check("R5 status returned", host_rd_data[7:0], 8'hF8);
    check("R5 divider untouched", {div_m, div_n}, {4'h4, 3'd2});
    check("R5 no divider strobe", n_div - d0, 0);
  endtask

  task automatic t_data();
    int t0 = n_tx, r0 = n_rx;
    issue(mk(1'b1, 3'd6, 1'b0, 3'd0, 8'hA5));
    wait_done("R7 data write duration", LAT);
    check("R7 tx byte loaded", tx_byte, 8'hA5);
    check("R7 tx strobe", n_tx - t0, 1);
    rx_byte = 8'h3C;
    issue(mk(1'b1, 3'd6, 1'b1, 3'd0, 8'hFF));
    wait_done("R7 data read duration", LAT);
    check("R7 rx byte returned", host_rd_data[7:0], 8'h3C);
    check("R7 rx strobe", n_rx - r0, 1);
    check("R7 tx byte unchanged by read", tx_byte, 8'hA5);
  endtask

  task automatic t_unused();
    int s0 = n_ctrl + n_tx + n_rx + n_div;
    issue(mk(1'b1, 3'd6, 1'b1, 3'd5, 8'h99));
    wait_done("R10 unused read duration", LAT);
    check("R10 unused read gives zero", host_rd_data[7:0], 8'h00);
    issue(mk(1'b1, 3'd6, 1'b0, 3'd1, 8'h42));
    wait_done("R10 unused write duration", LAT);
    check("R10 unused write keeps byte", host_rd_data[7:0], 8'h42);
    check("R10 no strobes", n_ctrl + n_tx + n_rx + n_div - s0, 0);
    check("R10 control unchanged", ctrl_byte, 8'h4C);
  endtask

  task automatic t_badop();
    int s0 = n_ctrl + n_tx + n_rx + n_div;
    issue(mk(1'b1, 3'd3, 1'b0, 3'd2, 8'h66));
    wait_done("R9 bad opcode duration", 1);
    check("R9 bad opcode data zero", host_rd_data[7:0], 8'h00);
    check("R9 control unchanged", ctrl_byte, 8'h4C);
    issue(mk(1'b1, 3'd7, 1'b1, 3'd3, 8'h55));
    wait_done("R9 bad opcode read duration", 1);
    check("R9 bad opcode read zero", host_rd_data[7:0], 8'h00);
    check("R9 no strobes", n_ctrl + n_tx + n_rx + n_div - s0, 0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] a = mk(1'b1, 3'd6, 1'b0, 3'd2, 8'h11);
    int c0 = n_ctrl;
    issue(a);
    issue(mk(1'b1, 3'd6, 1'b0, 3'd2, 8'h77));
    wait_done("R8 remaining busy cycles", LAT - 1);
    check("R8 word is first command", host_rd_data, {1'b0, a[62:0]});
    check("R8 control from first command", ctrl_byte, 8'h11);
    repeat (3) @(negedge clk);
    check("R8 ignored write never starts", host_rd_data[63], 1'b0);
    check("R8 single control strobe", n_ctrl - c0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_div();
    t_status();
    t_data();
    t_unused();
    t_badop();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule